// File: doc/BRIEF.md
# Dual-Direction Selectable Baud Rate Generator

This block turns a single fixed reference clock into two 16x oversampling strobes for one serial channel: one paced for the receiver and one for the transmitter. Each direction has its own 4-bit rate code. A shared bank bit and a shared 3-bit extended-mode field choose which rate table the codes index. Each code, under the active bank and mode, resolves to a nominal baud rate. That rate resolves to a divisor equal to the reference frequency divided by sixteen times the baud rate, rounded to nearest. A free-running counter per direction then emits a one-cycle strobe once per divisor period.

The receive and transmit codes are normally the upper and lower nibbles of one written select byte. The register that holds them belongs to the surrounding logic. The divisors are constants built at elaboration from the reference-frequency parameter, so no divider hardware is used at run time. A registered copy of each direction's nominal baud rate is brought out for debugging.

Top module: `baud_gen_pair`

## Requirements
- R1: A direction with an assigned selection pulses its tick for one cycle every D cycles, where D = (REF_HZ + 8*baud) / (16*baud) in integer arithmetic (3686400 and 9600 baud give D = 24). When D = 1 the tick stays high on every cycle.
- R2: With ext_mode = 3'b000 and set_sel = 0, codes 0 to 12 select 50, 110, 134, 200, 300, 600, 1200, 1050, 2400, 4800, 7200, 9600 and 38400 baud.
- R3: With ext_mode = 3'b000 and set_sel = 1, codes 0 to 12 select 75, 110, 134, 150, 300, 600, 1200, 2000, 2400, 4800, 1800, 9600 and 19200 baud.
- R4: With ext_mode = 3'b001 and set_sel = 0, code 8 selects 14400, code 9 selects 28800, code 11 selects 57600 and code 12 selects 230400. With set_sel = 1, code 0 selects 450, code 3 selects 900, code 5 selects 3600 and code 12 selects 115200. All other codes in this mode are unassigned.
- R5: With ext_mode = 3'b101 and set_sel = 0, code 1 selects 880 baud and code 2 selects 1076 baud. Every other code in this mode is unassigned, and so is every code with set_sel = 1.
- R6: For an unassigned selection the tick is held low and the nominal-rate output reads 0. Unassigned selections are codes 13 to 15 in normal mode, the gaps listed in R4 and R5, and every ext_mode value other than 000, 001 and 101.
- R7: When any part of a direction's selection (code, set_sel or ext_mode) differs from the value registered at the previous clock edge, that direction's counter restarts. It issues no tick until D edges after the edge that registered the change, and it issues its first tick exactly there.
- R8: The receive and transmit dividers are independent. A change that touches only one direction's code leaves the other direction's tick phase and period untouched.
- R9: rx_rate_nom and tx_rate_nom show the nominal baud rate of the selection present at the previous clock edge, one cycle after the inputs change.
- R10: While rst_n is low at a clock edge, both ticks and both nominal-rate outputs are cleared. Each counter restarts from the selection present during reset, so its first tick comes D edges after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, frequency REF_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_code | input | 4 | Receive rate code (upper nibble of the select byte) |
| tx_code | input | 4 | Transmit rate code (lower nibble of the select byte) |
| set_sel | input | 1 | Rate bank select, shared by both directions |
| ext_mode | input | 3 | Extended table select: 000 normal, 001 table 1, 101 table 2 |
| rx_tick | output | 1 | 16x receive strobe |
| tx_tick | output | 1 | 16x transmit strobe |
| rx_rate_nom | output | 18 | Registered nominal receive baud rate, 0 when unassigned |
| tx_rate_nom | output | 18 | Registered nominal transmit baud rate, 0 when unassigned |

## Verification
A restart of one divider can land in the same cycle as a due tick of the other divider, and a shared bank or mode change restarts both dividers together. The bench provokes the first case by changing one direction's code while the other direction is running mid-period. It provokes the second by flipping set_sel or ext_mode while both directions are busy. A per-direction age counter in the bench is cleared only when that direction's own selection changes. Every cycle, the bench compares each tick with the cycle in which that direction's divisor predicts it, so a restart that leaks into the untouched direction, or a stale tick from the old divisor, shows up as a mismatch in that exact cycle.

// File: rtl/baud_gen_pkg.sv
// Shared types and elaboration-time rate arithmetic for the baud generator.
// Assumes rows are numbered {mode_row[1:0], bank, code[3:0]}; mode row 3 is unassigned.
package baud_gen_pkg;

    typedef struct packed {
        logic [2:0] mode;
        logic       bank;
        logic [3:0] code;
    } rate_sel_t;

    localparam int ROW_W = 7;
    localparam int TBL_N = 1 << ROW_W;

    // Map the 3-bit extended-mode field to a table row group (3 = unassigned).
    function automatic logic [1:0] mode_row(input logic [2:0] m);
        case (m)
            3'b000:  return 2'd0;
            3'b001:  return 2'd1;
            3'b101:  return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    // Nominal baud rate of a table row; 0 marks an unassigned row.
    function automatic int unsigned nominal_baud(input int unsigned row);
        logic [1:0] mr;
        logic       bk;
        logic [3:0] cd;
        mr = 2'(row >> 5);
        bk = 1'(row >> 4);
        cd = 4'(row);
        case ({mr, bk})
            3'b000: case (cd)
                4'd0: return 50;     4'd1: return 110;   4'd2: return 134;
                4'd3: return 200;    4'd4: return 300;   4'd5: return 600;
                4'd6: return 1200;   4'd7: return 1050;  4'd8: return 2400;
                4'd9: return 4800;   4'd10: return 7200; 4'd11: return 9600;
                4'd12: return 38400;
                default: return 0;
            endcase
            3'b001: case (cd)
                4'd0: return 75;     4'd1: return 110;   4'd2: return 134;
                4'd3: return 150;    4'd4: return 300;   4'd5: return 600;
                4'd6: return 1200;   4'd7: return 2000;  4'd8: return 2400;
                4'd9: return 4800;   4'd10: return 1800; 4'd11: return 9600;
                4'd12: return 19200;
                default: return 0;
            endcase
            3'b010: case (cd)
                4'd8: return 14400;  4'd9: return 28800;
                4'd11: return 57600; 4'd12: return 230400;
                default: return 0;
            endcase
            3'b011: case (cd)
                4'd0: return 450;    4'd3: return 900;
                4'd5: return 3600;   4'd12: return 115200;
                default: return 0;
            endcase
            3'b100: case (cd)
                4'd1: return 880;    4'd2: return 1076;
                default: return 0;
            endcase
            default: return 0;
        endcase
    endfunction

    // Divisor rounded to nearest; 0 when the baud rate is unassigned.
    function automatic int unsigned divisor_for(input int unsigned ref_hz,
                                                input int unsigned os,
                                                input int unsigned baud);
        if (baud == 0) return 0;
        return (ref_hz + (os * baud) / 2) / (os * baud);
    endfunction

endpackage

// File: rtl/brg_rate_lookup.sv
// Resolves one direction's selection to a divisor and a nominal baud rate.
// Assumes both tables are constants built at elaboration from REF_HZ; no runtime division.
module brg_rate_lookup
    import baud_gen_pkg::*;
#(
    parameter int unsigned REF_HZ     = 3686400,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int          CNT_W      = 13,
    parameter int          BAUD_W     = 18
) (
    input  rate_sel_t           sel_i,
    output logic [CNT_W-1:0]    div_o,
    output logic [BAUD_W-1:0]   baud_o
);

    logic [CNT_W-1:0]  div_tbl  [TBL_N];
    logic [BAUD_W-1:0] baud_tbl [TBL_N];
    logic [ROW_W-1:0]  row;

    // Elaboration-time tables, one entry per row.
    for (genvar g = 0; g < TBL_N; g++) begin : g_row
        localparam int unsigned B = nominal_baud(g);
        assign baud_tbl[g] = BAUD_W'(B);
        assign div_tbl[g]  = CNT_W'(divisor_for(REF_HZ, OVERSAMPLE, B));
    end

    // Row index from mode group, bank and code.
    always_comb begin
        row    = {mode_row(sel_i.mode), sel_i.bank, sel_i.code};
        div_o  = div_tbl[row];
        baud_o = baud_tbl[row];
    end

endmodule

// File: rtl/brg_divider.sv
// Free-running tick divider for one direction.
// Assumes div_i is constant while sel_i is constant; div_i = 0 means idle.
module brg_divider
    import baud_gen_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rate_sel_t        sel_i,
    input  logic [CNT_W-1:0] div_i,
    output logic             tick_o
);

    rate_sel_t        sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic             reload;

    // Any change of the selection since the last edge restarts the count.
    assign reload = (sel_i != sel_q);

    // Counter: restart on change or idle, strobe and wrap at the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= sel_i;
            cnt_q  <= CNT_W'(1);
            tick_o <= 1'b0;
        end else begin
            sel_q <= sel_i;
            if (reload || div_i == '0) begin
                cnt_q  <= CNT_W'(1);
                tick_o <= 1'b0;
            end else if (cnt_q == div_i) begin
                cnt_q  <= CNT_W'(1);
                tick_o <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
                tick_o <= 1'b0;
            end
        end
    end

    // R7: the cycle after a restart carries no stale tick.
    assert_reload_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !tick_o);

    // R1: with a divisor above one, ticks are single-cycle pulses.
    assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i > CNT_W'(1)) |=> !tick_o);

    // R6: an unassigned selection keeps the tick low.
    assert_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_i == '0) |=> !tick_o);

    // R10: a reset edge clears the tick.
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> !tick_o);

endmodule

// File: rtl/baud_gen_pair.sv
// Top: independent receive and transmit 16x tick generators sharing bank and mode.
// Assumes clk runs at REF_HZ; the select register lives outside this block.
module baud_gen_pair
    import baud_gen_pkg::*;
#(
    parameter int unsigned REF_HZ     = 3686400,
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned MIN_BAUD   = 50,
    parameter int          BAUD_W     = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rx_code,
    input  logic [3:0]        tx_code,
    input  logic              set_sel,
    input  logic [2:0]        ext_mode,
    output logic              rx_tick,
    output logic              tx_tick,
    output logic [BAUD_W-1:0] rx_rate_nom,
    output logic [BAUD_W-1:0] tx_rate_nom
);

    localparam int unsigned MAX_DIV = divisor_for(REF_HZ, OVERSAMPLE, MIN_BAUD);
    localparam int          CNT_W   = $clog2(MAX_DIV + 1);
    localparam int          N_DIR   = 2;

    logic              tick_w [N_DIR];
    logic [BAUD_W-1:0] nom_q  [N_DIR];

    // One lookup, divider and debug register per direction (0 = rx, 1 = tx).
    for (genvar ch = 0; ch < N_DIR; ch++) begin : g_dir
        rate_sel_t         sel;
        logic [CNT_W-1:0]  div;
        logic [BAUD_W-1:0] baud;

        assign sel = {ext_mode, set_sel, (ch == 0) ? rx_code : tx_code};

        brg_rate_lookup #(
            .REF_HZ    (REF_HZ),
            .OVERSAMPLE(OVERSAMPLE),
            .CNT_W     (CNT_W),
            .BAUD_W    (BAUD_W)
        ) u_lookup (
            .sel_i (sel),
            .div_o (div),
            .baud_o(baud)
        );

        brg_divider #(.CNT_W(CNT_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_i (sel),
            .div_i (div),
            .tick_o(tick_w[ch])
        );

        // Debug copy of the nominal rate, one cycle behind the inputs.
        always_ff @(posedge clk) begin
            if (!rst_n) nom_q[ch] <= '0;
            else        nom_q[ch] <= baud;
        end

        // R6: a zero nominal rate never coincides with a tick.
        assert_nom_zero_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (nom_q[ch] == '0) |-> !tick_w[ch]);
    end

    assign rx_tick     = tick_w[0];
    assign tx_tick     = tick_w[1];
    assign rx_rate_nom = nom_q[0];
    assign tx_rate_nom = nom_q[1];

endmodule

// File: tb/baud_gen_pair_tb.sv
module baud_gen_pair_tb;

    localparam int REF = 3686400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rxc = 4'd11, txc = 4'd12;
    logic        bank = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic        rx_tick, tx_tick;
    logic [17:0] rx_nom, tx_nom;

    int    checks = 0, fails = 0, cycles = 0;
    int    rx_age = 0, tx_age = 0;
    string phase = "R10";

    always #2 clk = ~clk;

    baud_gen_pair u_dut (
        .clk(clk), .rst_n(rst_n), .rx_code(rxc), .tx_code(txc),
        .set_sel(bank), .ext_mode(mode), .rx_tick(rx_tick), .tx_tick(tx_tick),
        .rx_rate_nom(rx_nom), .tx_rate_nom(tx_nom)
    );

    // Rate tables as stated in R2..R6.
    function automatic int exp_baud(input logic [2:0] m, input logic b, input logic [3:0] c);
        int n0 [13] = '{50, 110, 134, 200, 300, 600, 1200, 1050, 2400, 4800, 7200, 9600, 38400};
        int n1 [13] = '{75, 110, 134, 150, 300, 600, 1200, 2000, 2400, 4800, 1800, 9600, 19200};
        if (m == 3'b000) begin
            if (c > 4'd12) return 0;
            return b ? n1[c] : n0[c];
        end
        if (m == 3'b001 && !b)
            return (c == 8) ? 14400 : (c == 9) ? 28800 : (c == 11) ? 57600 : (c == 12) ? 230400 : 0;
        if (m == 3'b001 && b)
            return (c == 0) ? 450 : (c == 3) ? 900 : (c == 5) ? 3600 : (c == 12) ? 115200 : 0;
        if (m == 3'b101 && !b)
            return (c == 1) ? 880 : (c == 2) ? 1076 : 0;
        return 0;
    endfunction

    // R1 divisor.
    function automatic int exp_div(input int baud);
        if (baud == 0) return 0;
        return (REF + 8 * baud) / (16 * baud);
    endfunction

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
        end
    endtask

    // Advance one cycle and compare both directions against the model.
    task automatic sample();
        int d;
        @(negedge clk);
        rx_age++;
        tx_age++;
        d = exp_div(exp_baud(mode, bank, rxc));
        chk("rx_tick", rx_tick, (d != 0 && rx_age > 0 && rx_age % d == 0));
        d = exp_div(exp_baud(mode, bank, txc));
        chk("tx_tick", tx_tick, (d != 0 && tx_age > 0 && tx_age % d == 0));
        chk("rx_rate_nom (R9)", rx_nom, exp_baud(mode, bank, rxc));
        chk("tx_rate_nom (R9)", tx_nom, exp_baud(mode, bank, txc));
    endtask

    // Drive a new selection at a negedge; a changed direction restarts (R7).
    task automatic apply(input logic [3:0] r, input logic [3:0] t,
                         input logic b, input logic [2:0] m);
        if ({m, b, r} != {mode, bank, rxc}) rx_age = -1;
        if ({m, b, t} != {mode, bank, txc}) tx_age = -1;
        rxc = r; txc = t; bank = b; mode = m;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) sample();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 190000);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0BA5));
        // R10: outputs cleared while reset is held.
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("rx_tick in reset", rx_tick, 0);
            chk("tx_tick in reset", tx_tick, 0);
            chk("rx_rate_nom in reset", rx_nom, 0);
            chk("tx_rate_nom in reset", tx_nom, 0);
        end
        rst_n = 1'b1;
        rx_age = 0;
        tx_age = 0;
        // R10 then R2: first ticks counted from the last reset edge (9600 and 38400).
        run(80);
        // R3: bank 1, 19200 and 75 baud.
        phase = "R3";
        apply(4'd12, 4'd0, 1'b1, 3'b000);
        run(3100);
        // R4: table 1, 230400 (D=1) and 57600.
        phase = "R4";
        apply(4'd12, 4'd11, 1'b0, 3'b001);
        run(40);
        apply(4'd12, 4'd3, 1'b1, 3'b001);
        run(560);
        // R5: table 2, 880 and 1076.
        phase = "R5";
        apply(4'd1, 4'd2, 1'b0, 3'b101);
        run(560);
        // R6: unassigned codes, modes and gaps.
        phase = "R6";
        apply(4'd13, 4'd15, 1'b0, 3'b000);
        run(60);
        apply(4'd11, 4'd12, 1'b0, 3'b010);
        run(60);
        apply(4'd3, 4'd0, 1'b1, 3'b101);
        run(60);
        // R7: change mid-period, 9600 to 7200 after a partial count.
        phase = "R7";
        apply(4'd11, 4'd11, 1'b0, 3'b000);
        run(37);
        apply(4'd10, 4'd11, 1'b0, 3'b000);
        run(100);
        // R8: only tx changes while rx keeps its phase, repeated at odd offsets.
        phase = "R8";
        for (int k = 0; k < 6; k++) begin
            apply(rxc, (k % 2) ? 4'd12 : 4'd9, 1'b0, 3'b000);
            run(13 + 7 * k);
        end
        run(60);
        // R1: constrained random selections, both shared and per-direction changes.
        phase = "R1";
        for (int k = 0; k < 40; k++) begin
            logic [2:0] m;
            logic [3:0] r, t;
            int         pick;
            pick = $urandom % 4;
            m = (pick == 0) ? 3'b000 : (pick == 1) ? 3'b001 : (pick == 2) ? 3'b101 : 3'($urandom);
            r = 4'($urandom);
            t = 4'($urandom);
            case ($urandom % 3)
                0:       apply(r, txc, bank, mode);
                1:       apply(rxc, t, bank, mode);
                default: apply(r, t, 1'($urandom), m);
            endcase
            run(150 + int'($urandom % 400));
        end
        finish_run();
    end

endmodule